// File: doc/BRIEF.md
# Serial Debug Link Host Master

This block is the host end of a synchronous, bit-serial background-debug link. A host presents one request on a parallel interface. The request carries an operation code, a transfer direction, an operand size, a register kind and number, an optional 32-bit memory address and optional write data. The block packs these fields into a 16-bit command word. It then sends that word, followed by any 16-bit extension words, to the target as a series of 17-bit frames on a gated serial clock.

The serial clock rests high and dips low once per bit. The rate is set by a divider value, which the block latches when it accepts a request. In every frame the block also captures a 17-bit word from the target. The first received bit is a status flag and the other sixteen bits form a response word. When the last frame of a request ends, the block pulses `done` and presents the response and status from that final frame. A request that uses the reserved size code is refused: the block pulses an error flag and sends nothing.

Top module: `dbg_serial_master`

## Requirements
- R1: While idle, `sclk` is held high. A frame consists of exactly 17 low pulses of `sclk`, one for each bit.
- R2: With divider value D latched at acceptance, each low half and each high half of a bit lasts D+1 cycles of `clk`.
- R3: The command word is {op[5:0], 1'b0, rd, size[1:0], 2'b00, ad, regsel[2:0]}, from bit 15 down to bit 0. `rd`=1 means data moves from the target to the host. `ad`=1 selects an address register and `ad`=0 a data register.
- R4: A request accepted while idle with `size`=2'b11 (reserved) raises `err` for one cycle on the following clock. `busy` stays low and no `sclk` pulse is produced.
- R5: When `has_addr`=1, the 32-bit address follows the command word as two extension frames, the upper half first.
- R6: Size codes are 00 byte, 01 word and 10 long. A write (`rd`=0) appends data frames after any address frames. A long sends `wdata[31:16]` and then `wdata[15:0]`. A word sends `wdata[15:0]`. A byte sends {8'h00, `wdata[7:0]`}. A read appends no data frames.
- R7: In each frame the host first sends a 0 bit and then the 16-bit word, MSB first. `sdo` changes only while `sclk` is high.
- R8: `sdi` is sampled on each rising edge of `sclk`. The first bit sampled in the final frame appears on `stat` and the remaining 16 bits, first-received in the MSB, appear on `resp`.
- R9: `busy` rises on the clock after a request is accepted and stays high until the last frame ends. It then falls in the same cycle as a one-cycle `done` pulse. `resp` and `stat` hold their values until the next `done`.
- R10: `req_valid` has no effect while `busy` is high, whatever the request fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div | input | DIV_W | Half-bit length minus one, in clk cycles |
| req_valid | input | 1 | Request strobe, taken when idle |
| op | input | 6 | Operation code |
| rd | input | 1 | Direction, 1 = target to host |
| size | input | 2 | Operand size code |
| ad | input | 1 | Register kind, 1 = address |
| regsel | input | 3 | Register number |
| has_addr | input | 1 | Append 32-bit address extension |
| addr | input | 32 | Memory address |
| wdata | input | 32 | Write operand |
| sclk | output | 1 | Gated serial clock, idles high |
| sdo | output | 1 | Serial data to target |
| sdi | input | 1 | Serial data from target |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle reserved-size rejection |
| resp | output | 16 | Response word of the final frame |
| stat | output | 1 | Status bit of the final frame |

## Verification
A bad bit counter would show up inside the first frame, as a run of low pulses that is not 17 long. A bad timer would show up at the first half-bit, as a low or high width that differs from D+1. A broken word queue would make the frame count or the order of extension frames differ from the request, and the target model would see this as soon as the affected frame ends. A fault in the receive path would make `resp` or `stat` wrong in the same cycle as `done`.

// File: rtl/dbg_serial_master.sv
module dbg_serial_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             req_valid,
  input  logic [5:0]       op,
  input  logic             rd,
  input  logic [1:0]       size,
  input  logic             ad,
  input  logic [2:0]       regsel,
  input  logic             has_addr,
  input  logic [31:0]      addr,
  input  logic [31:0]      wdata,
  output logic             sclk,
  output logic             sdo,
  input  logic             sdi,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [15:0]      resp,
  output logic             stat
);
  localparam int FRAME_BITS = 17;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} st_t;
  st_t st;

  logic [DIV_W-1:0] div_q, cnt;
  logic [63:0]      q;
  logic [2:0]       nleft;
  logic [4:0]       bitn;
  logic [16:0]      sh_out, sh_in;

  logic [15:0] cmd;
  logic [31:0] dat;
  logic [1:0]  nd;
  logic [63:0] tail;
  logic [2:0]  ntail;
  logic        tick;

  assign cmd  = {op, 1'b0, rd, size, 2'b00, ad, regsel};
  assign tick = (cnt == div_q);
  assign sclk = (st != S_LO);
  assign sdo  = sh_out[16];
  assign busy = (st != S_IDLE);

  always_comb begin
    dat = 32'h0;
    nd  = 2'd0;
    if (!rd) begin
      case (size)
        2'b00:   begin dat = {8'h00, wdata[7:0], 16'h0}; nd = 2'd1; end
        2'b01:   begin dat = {wdata[15:0], 16'h0};       nd = 2'd1; end
        default: begin dat = wdata;                      nd = 2'd2; end
      endcase
    end
    tail  = has_addr ? {addr, dat} : {dat, 32'h0};
    ntail = (has_addr ? 3'd2 : 3'd0) + {1'b0, nd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      div_q  <= '0;
      cnt    <= '0;
      q      <= '0;
      nleft  <= '0;
      bitn   <= '0;
      sh_out <= '0;
      sh_in  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      resp   <= '0;
      stat   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (size == 2'b11) begin
              err <= 1'b1;
            end else begin
              q      <= tail;
              nleft  <= ntail;
              sh_out <= {1'b0, cmd};
              bitn   <= '0;
              cnt    <= '0;
              div_q  <= div;
              st     <= S_HI;
            end
          end
        end
        S_HI: begin
          if (tick) begin
            cnt <= '0;
            if (bitn == 5'(FRAME_BITS)) begin
              if (nleft == 3'd0) begin
                st   <= S_IDLE;
                done <= 1'b1;
                resp <= sh_in[15:0];
                stat <= sh_in[16];
              end else begin
                sh_out <= {1'b0, q[63:48]};
                q      <= q << 16;
                nleft  <= nleft - 3'd1;
                bitn   <= '0;
              end
            end else begin
              st <= S_LO;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LO: begin
          if (tick) begin
            cnt    <= '0;
            st     <= S_HI;
            sh_in  <= {sh_in[15:0], sdi};
            sh_out <= {sh_out[15:0], 1'b0};
            bitn   <= bitn + 5'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dbg_serial_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] size,
  input logic       sclk,
  input logic       sdo,
  input logic       busy,
  input logic       done,
  input logic       err
);
  a_r1_idle_sclk_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);

  a_r4_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && size == 2'b11) |=> (err && !busy));

  a_r7_sdo_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(sdo));

  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  a_r10_no_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !err);
endmodule

bind dbg_serial_master dbg_serial_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .size(size),
  .sclk(sclk), .sdo(sdo), .busy(busy), .done(done), .err(err)
);

// File: tb/dbg_serial_master_tb.sv
module dbg_serial_master_tb_top;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic req_valid = 1'b0;
  logic [5:0] op = '0;
  logic rd = 1'b0;
  logic [1:0] size = '0;
  logic ad = 1'b0;
  logic [2:0] regsel = '0;
  logic has_addr = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic sclk, sdo, busy, done, err, stat;
  logic sdi = 1'b0;
  logic [15:0] resp;

  int n_chk = 0, n_fail = 0;

  dbg_serial_master #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .div(div), .req_valid(req_valid), .op(op),
    .rd(rd), .size(size), .ad(ad), .regsel(regsel), .has_addr(has_addr),
    .addr(addr), .wdata(wdata), .sclk(sclk), .sdo(sdo), .sdi(sdi),
    .busy(busy), .done(done), .err(err), .resp(resp), .stat(stat)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] tgt_word(input int g);
    int m;
    m = g * 32'h1357;
    return {g[0], 16'hA5C3 ^ m[15:0]};
  endfunction

  // target model
  logic [16:0] rxw [0:7];
  logic [16:0] rxsh = '0;
  int nf = 0, gf = 0, fcnt = 0, lowcnt = 0, hicnt = 0, cur_div = 0;
  logic prev = 1'b1;
  logic [16:0] tw;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev = 1'b1; fcnt = 0;
    end else begin
      if (prev && !sclk) begin
        if (fcnt > 0) chk(hicnt == cur_div + 1, "R2 high half", hicnt, cur_div + 1);
        rxsh = {rxsh[15:0], sdo};
        tw = tgt_word(gf);
        sdi = tw[16 - fcnt];
        fcnt++;
        lowcnt = 1;
        if (fcnt == 17) begin
          if (nf < 8) rxw[nf] = rxsh;
          nf++; gf++; fcnt = 0;
        end
      end else if (!sclk) begin
        lowcnt++;
      end else if (!prev && sclk) begin
        chk(lowcnt == cur_div + 1, "R2 low half", lowcnt, cur_div + 1);
        hicnt = 1;
      end else begin
        hicnt++;
      end
      prev = sclk;
    end
  end

  task automatic run(input int d, input int o, input bit r, input int sz,
                     input bit ha, input bit a, input int rg);
    logic [15:0] exw [0:4];
    int nexp, g0, t;
    logic [31:0] wd, ad32;
    logic [16:0] last;
    logic [15:0] held;
    wd   = 32'h5A3C_0000 ^ (o * 32'h0101_0F0F) ^ 32'(sz * 1234567);
    ad32 = 32'hC001_0000 | 32'(o * 977);
    @(negedge clk);
    div = DIV_W'(d); cur_div = d;
    op = 6'(o); rd = r; size = 2'(sz); has_addr = ha; ad = a; regsel = 3'(rg);
    addr = ad32; wdata = wd; req_valid = 1'b1;
    nf = 0; g0 = gf;
    @(negedge clk);
    req_valid = 1'b0;
    if (sz == 3) begin
      chk(err == 1'b1 && busy == 1'b0, "R4 reserved err", {err, busy}, 2'b10);
      repeat (40) @(negedge clk);
      chk(nf == 0 && sclk == 1'b1 && fcnt == 0, "R4 nothing sent", nf, 0);
      return;
    end
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    nexp = 0;
    exw[nexp++] = 16'(o * 1024 + int'(r) * 256 + sz * 64 + int'(a) * 8 + rg);
    if (ha) begin exw[nexp++] = ad32[31:16]; exw[nexp++] = ad32[15:0]; end
    if (!r) begin
      if (sz == 2) begin exw[nexp++] = wd[31:16]; exw[nexp++] = wd[15:0]; end
      else if (sz == 1) exw[nexp++] = wd[15:0];
      else exw[nexp++] = {8'h00, wd[7:0]};
    end
    // R10: a request (even reserved) while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; size = 2'b11; op = ~op; has_addr = ~ha;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b0 && busy == 1'b1, "R10 ignored while busy", {err, busy}, 2'b01);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1 && busy == 1'b0, "R9 done with busy low", {done, busy}, 2'b10);
    chk(nf == nexp, "R5/R6 frame count", nf, nexp);
    for (int i = 0; i < nexp && i < 8; i++) begin
      chk(rxw[i][16] == 1'b0, "R7 lead bit zero", rxw[i][16], 0);
      chk(rxw[i][15:0] == exw[i], i == 0 ? "R3 command word" :
          (ha && i < 3) ? "R5 address word" : "R6 data word", rxw[i][15:0], exw[i]);
    end
    last = tgt_word(g0 + nexp - 1);
    chk(resp == last[15:0], "R8 response word", resp, last[15:0]);
    chk(stat == last[16], "R8 status bit", stat, last[16]);
    held = resp;
    repeat (3) @(negedge clk);
    chk(resp == held && sclk == 1'b1 && busy == 1'b0, "R9/R1 idle hold", resp, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1 && busy == 1'b0 && done == 1'b0 && err == 1'b0,
        "R1/R9 reset state", {sclk, busy, done, err}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    begin
      int k;
      k = 0;
      for (int d = 0; d < 3; d++)
        for (int sz = 0; sz < 4; sz++)
          for (int r = 0; r < 2; r++)
            for (int ha = 0; ha < 2; ha++) begin
              run(d, (k * 7 + 5) % 64, r[0], sz, ha[0], k[0], k % 8);
              k++;
            end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule